// File: doc/BRIEF.md
# Dual-Rail Completion-Sensing Adder

This block adds two single-rail operands and reports by itself when the sum is settled. Its latency therefore depends on the data and is not a fixed count. Every bit position keeps its outgoing carry on a pair of wires. One wire says "carry out is one". The other says "carry out is zero". When both wires are low, the carry is not yet known. A position whose two operand bits are equal knows its carry at once. A position whose bits differ must wait for the position below it and then repeats that position's value.

The model is synchronous. One clock edge moves a resolved carry up by one position. While the enable input is low, every rail is cleared to the unknown state, so no stale completion can be seen. The user sets up the operands and the incoming carry pair, raises enable, and then waits for the done output. The sum and carry-out are valid while done is high. If both wires of any position are high at once, an error flag is raised.

Top module: `dr_cc_adder`

## Requirements
- R1: While reset is high, or on any clock edge at which `en` is low, every carry rail is cleared. From the next cycle on, `done`, `rail_err`, `cout` and all bits of `sum` read 0.
- R2: A position whose operand bits are both 1 drives its carry-one rail, and a position whose bits are both 0 drives its carry-zero rail. Either case takes effect on the first clock edge with `en` high. If all positions have equal bits, `done` is high one cycle after `en` is first seen high.
- R3: A position whose operand bits differ copies both rails of the position below it, one edge after that position has resolved. Position 0 copies the incoming pair (`cin_one`, `cin_zero`) on the first edge with `en` high.
- R4: `done` is high exactly when every position has at least one rail high. Its latency in edges is the largest resolve time over all positions. An equal-bit position resolves at time 1. A differing-bit position resolves at one more than the position below it, and position 0 counts as time 1 when the incoming pair is resolved. Once `done` is high, it stays high while `en` and the inputs are held.
- R5: While `done` is high, `sum` equals (a + b + cin) mod 2^W and `cout` is the carry out of the top position, where cin is 1 when `cin_one` is high. While `done` is low, `sum` and `cout` read 0.
- R6: `rail_err` is high whenever some position has both rails high. This happens when `cin_one` and `cin_zero` are both high and reach position 0 through differing bits.
- R7: If both incoming rails are low, the differing-bit positions chained to position 0 never resolve, and `done` stays low for as long as `en` is held.
- R8: The operand width `W` is a parameter with a default of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Start of addition; low clears all rails |
| a | input | W | Operand A |
| b | input | W | Operand B |
| cin_one | input | 1 | Incoming carry rail meaning carry is one |
| cin_zero | input | 1 | Incoming carry rail meaning carry is zero |
| sum | output | W | Sum, valid while done is high, else 0 |
| cout | output | 1 | Carry out of the top position, gated like sum |
| done | output | 1 | All positions have resolved their carry |
| rail_err | output | 1 | Some position has both rails high |

## Verification
The completion signal and the error flag can rise in the same cycle. An illegal incoming pair (both rails high) still counts as resolved, so it can finish the chain while it also raises the error. The bench drives both incoming rails high under operands whose positions all differ. It then checks that `rail_err` is up one edge after enable, and that `done` rises only after the full propagate chain, with `rail_err` still high in that cycle. Separately, a table of operand pairs is checked for both exact latency and sum against a resolve-time model computed in the bench.

// File: rtl/dr_cc_pkg.sv
package dr_cc_pkg;
  typedef struct packed {
    logic one;
    logic zero;
  } rail_t;

  localparam rail_t RAIL_NULL = '{one: 1'b0, zero: 1'b0};

  function automatic logic rail_known(input rail_t r);
    return r.one | r.zero;
  endfunction

  function automatic logic rail_bad(input rail_t r);
    return r.one & r.zero;
  endfunction
endpackage

// File: rtl/dr_cc_stage.sv
module dr_cc_stage
  import dr_cc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  a,
  input  logic  b,
  input  rail_t below,
  output rail_t q
);
  rail_t nxt;

  always_comb begin
    if (a == b) begin
      nxt.one  = a & b;
      nxt.zero = ~(a | b);
    end else begin
      nxt = below;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) q <= RAIL_NULL;
    else            q <= nxt;
  end
endmodule

// File: rtl/dr_cc_detect.sv
module dr_cc_detect
  import dr_cc_pkg::*;
#(
  parameter int W = 16
) (
  input  rail_t [W-1:0] rails,
  output logic          all_known,
  output logic          any_bad
);
  logic [W-1:0] known_v;
  logic [W-1:0] bad_v;

  for (genvar i = 0; i < W; i++) begin : g_pos
    assign known_v[i] = rail_known(rails[i]);
    assign bad_v[i]   = rail_bad(rails[i]);
  end

  assign all_known = &known_v;
  assign any_bad   = |bad_v;
endmodule

// File: rtl/dr_cc_adder.sv
module dr_cc_adder
  import dr_cc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin_one,
  input  logic         cin_zero,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         done,
  output logic         rail_err
);
  localparam int TOP = W - 1;

  rail_t        cin_r;
  rail_t [W-1:0] rails;
  rail_t [W-1:0] below;
  logic  [W-1:0] carry_in;

  assign cin_r.one  = cin_one;
  assign cin_r.zero = cin_zero;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign below[i]    = cin_r;
      assign carry_in[i] = cin_one;
    end else begin : g_up
      assign below[i]    = rails[i-1];
      assign carry_in[i] = rails[i-1].one;
    end

    dr_cc_stage u_stage (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .a     (a[i]),
      .b     (b[i]),
      .below (below[i]),
      .q     (rails[i])
    );
  end

  dr_cc_detect #(.W(W)) u_detect (
    .rails     (rails),
    .all_known (done),
    .any_bad   (rail_err)
  );

  assign sum  = done ? (a ^ b ^ carry_in) : '0;
  assign cout = done & rails[TOP].one;
endmodule

// File: rtl/dr_cc_adder_chk.sv
module dr_cc_adder_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin_one,
  input logic         cin_zero,
  input logic [W-1:0] sum,
  input logic         cout,
  input logic         done,
  input logic         rail_err
);
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!done && !rail_err)); // R1

  AST_EQUAL_BITS_FAST: assert property (@(posedge clk) disable iff (rst)
    (en && a == b) |=> done); // R2

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (en && done && $stable(a) && $stable(b) && $stable(cin_one) && $stable(cin_zero)) |=> done); // R4

  AST_GATED_RESULT: assert property (@(posedge clk) disable iff (rst)
    !done |-> (sum == '0 && !cout)); // R5

  AST_ERR_NEEDS_BAD_CIN: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_err) |-> $past(cin_one && cin_zero)); // R6
endmodule

bind dr_cc_adder dr_cc_adder_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .a(a), .b(b),
  .cin_one(cin_one), .cin_zero(cin_zero),
  .sum(sum), .cout(cout), .done(done), .rail_err(rail_err)
);

// File: tb/dr_cc_adder_tb.sv
module dr_cc_adder_tb_top;
  localparam int W = 16;
  localparam int NV = 6;
  localparam int INF = 1000;
  // each vector: {a, b, cin_one, cin_zero}
  localparam logic [2*W+1:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 2'b01},
    {16'hFFFF, 16'h0001, 2'b01},
    {16'h00FF, 16'hFF00, 2'b10},
    {16'h1234, 16'h4321, 2'b01},
    {16'hAAAA, 16'h5555, 2'b01},
    {16'h8001, 16'h8001, 2'b10}
  };

  logic clk = 0, rst = 1, en = 0;
  logic [W-1:0] a = '0, b = '0;
  logic cin_one = 0, cin_zero = 0;
  logic [W-1:0] sum;
  logic cout, done, rail_err;
  int checks = 0, errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dr_cc_adder #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .en(en), .a(a), .b(b),
    .cin_one(cin_one), .cin_zero(cin_zero),
    .sum(sum), .cout(cout), .done(done), .rail_err(rail_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_lat(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic c1, input logic c0);
    int t, mx;
    t = (c1 | c0) ? 1 : INF;
    mx = 0;
    for (int i = 0; i < W; i++) begin
      if (x[i] == y[i]) t = 1;
      else if (i > 0) t = (t >= INF) ? INF : t + 1;
      if (t > mx) mx = t;
    end
    return mx;
  endfunction

  task automatic start(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic c1, input logic c0);
    @(negedge clk);
    en = 0;
    @(negedge clk);
    a = x; b = y; cin_one = c1; cin_zero = c0;
    en = 1;
  endtask

  task automatic run_to_done(input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!done && n < limit);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic [W:0] full;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done at reset", done, 0);
    check("R1 sum at reset", sum, 0);
    check("R1 err at reset", rail_err, 0);
    rst = 0;

    // R8 width, R2/R3/R4/R5: table walk
    check("R8 width", $bits(sum), 16);
    for (int k = 0; k < NV; k++) begin
      logic [W-1:0] x, y;
      logic c1, c0;
      {x, y, c1, c0} = VEC[k];
      start(x, y, c1, c0);
      run_to_done(W + 4, n);
      full = x + y + c1;
      check("R4 latency", n, model_lat(x, y, c1, c0));
      check("R5 sum", sum, full[W-1:0]);
      check("R5 cout", cout, full[W]);
      check("R6 no err on legal cin", rail_err, 0);
    end

    // R2: all-equal operands finish after one edge
    start(16'h0F0F, 16'h0F0F, 1'b0, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R2 one-edge done", done, 1);
    check("R2 sum", sum, 16'h1E1E);

    // R3: differing bit 0 copies cin after first edge; chain of 3 above
    start(16'h0007, 16'h0000, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R3 not done after 1 edge", done, 0);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R3 done after 3 edges", done, 1);
    check("R3 sum", sum, 16'h0008);

    // R1: drop enable mid-chain
    start(16'hFFFF, 16'h0000, 1'b1, 1'b0);
    repeat (4) begin @(posedge clk); @(negedge clk); end
    en = 0;
    @(posedge clk); @(negedge clk);
    check("R1 cleared after en low", done, 0);
    check("R1 sum cleared", sum, 0);

    // R7: unresolved incoming carry never finishes
    start(16'h0001, 16'h0000, 1'b0, 1'b0);
    run_to_done(W + 6, n);
    check("R7 done stays low", done, 0);

    // R6 with R4: bad incoming pair, error and done together
    start(16'h00FF, 16'hFF00, 1'b1, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R6 err after first edge", rail_err, 1);
    check("R6 not done yet", done, 0);
    run_to_done(W + 4, n);
    check("R6 done latency with bad cin", n + 1, W);
    check("R6 err with done", rail_err, 1);
    en = 0;
    @(posedge clk); @(negedge clk);
    check("R1 err cleared", rail_err, 0);

    // R1: reset mid-run
    start(16'h1111, 16'h1111, 1'b0, 1'b1);
    rst = 1;
    @(posedge clk); @(negedge clk);
    check("R1 reset clears", done, 0);
    rst = 0;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule